// File: doc/BRIEF.md
# External Data Access Steering Controller

This block sits between a small 8-bit core and two data targets: an on-chip auxiliary RAM and an external multiplexed address/data bus. The core hands it one request at a time. Each request is a read or a write, with either a short (8-bit) or a wide (16-bit) pointer. A control register sets three things: how much of the on-chip RAM is visible, whether the internal RAM is bypassed completely, and how long the external read and write strobes last. From these the block decides where each access goes.

An internal access drives only the RAM-side port and leaves every external pin idle. An external access runs in two phases. In the address phase, the low byte of the address goes on the low port while an address latch strobe pulses. In the strobe phase, an active-low read or write strobe runs for a programmable number of clocks. During a write the low port carries the write data. During a read the low port is sampled. For a wide pointer the high port carries the high address byte for the whole access. The block reports busy while an access runs and accepts a new request only when it is idle.

Top module: `xdata_steer`

## Requirements
- R1: After reset, `cfg_q` reads 0x0C, `busy` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_ale` is 0, `bus_lo_oe` is 0 and `bus_hi` is 0xFF.
- R2: Control register layout: bit 5 is the stretch bit, bits 3:2 are the size select, bit 1 is the map-all-external bit and bit 0 is the latch-strobe disable bit. Bits 7, 6 and 4 are reserved. They are never stored and always read 0, so writing 0xFF reads back 0x2F.
- R3: Size select values 00, 01, 10 and 11 make 256, 512, 768 and 1024 bytes of internal RAM visible. With the map bit clear, a wide-pointer access below the visible size is internal, and one at or above it is external.
- R4: An internal access asserts `iram_en` for exactly one cycle. It leaves both strobes high, `bus_ale` low, `bus_lo_oe` low and `bus_hi` at 0xFF. An internal read returns `rd_valid` two cycles after acceptance (busy for 2 cycles). An internal write is busy for 1 cycle.
- R5: With the map bit set, every access, short or wide, goes to the external bus.
- R6: A short-pointer access uses only `req_addr[7:0]`. With the map bit clear it always reaches internal RAM at that byte address. When it goes external, `bus_hi` stays at 0xFF.
- R7: On an external access, `bus_ale` pulses high for exactly one cycle while `bus_lo_out` carries the low address byte and `bus_lo_oe` is 1. For a wide pointer, `bus_hi` holds the high address byte for the whole access.
- R8: The read or write strobe stays low for 6 consecutive clocks when the stretch bit is 0, and for 30 when it is 1. An external access is busy for strobe length + 1 cycles.
- R9: During a write strobe, `bus_lo_oe` is 1 and `bus_lo_out` holds the write data for every cycle of the pulse.
- R10: On an external read, `bus_lo_in` is sampled in the last cycle of the read strobe. That value appears on `rd_data`, with `rd_valid` high for one cycle, in the cycle after the strobe rises. `bus_rd_n` and `bus_wr_n` are never low together.
- R11: A request is accepted only when `busy` is low. A request presented while busy has no effect.
- R12: With the latch-strobe disable bit set, `bus_ale` stays low. The one-cycle address phase and the strobe timing are otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit pointer |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write value |
| cfg_q | output | 8 | Control register read value |
| iram_en | output | 1 | Internal RAM access enable |
| iram_we | output | 1 | Internal RAM write enable |
| iram_addr | output | IRAM_AW | Internal RAM address |
| iram_wdata | output | 8 | Internal RAM write data |
| iram_rdata | input | 8 | Internal RAM read data, one clock after enable |
| bus_lo_out | output | 8 | Low port output: address low byte, then write data |
| bus_lo_oe | output | 1 | Low port output enable |
| bus_lo_in | input | 8 | Low port input for read data |
| bus_hi | output | 8 | High port: high address byte, 0xFF when idle |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
A request is accepted on the clock edge where `req_valid` is high and `busy` is low. `busy` rises from the next cycle on. It lasts 1 cycle for an internal write, 2 for an internal read, and strobe length + 1 for an external access. `rd_valid` and `rd_data` are valid in the first cycle in which `busy` is low again. The bench drives inputs and samples outputs on falling edges. It records latch, strobe, port and RAM-enable activity in every busy cycle. It reads the result in the first idle cycle, so each result is taken in the very cycle the timing above predicts.

// File: rtl/xdata_steer_pkg.sv
package xdata_steer_pkg;

  // Decoded control register fields.
  typedef struct packed {
    logic       stretch;
    logic [1:0] size_sel;
    logic       map_ext;
    logic       ale_off;
  } xs_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT,
    ST_IRD,
    ST_ADR,
    ST_STB
  } xs_state_e;

  localparam logic [7:0] XS_CFG_MASK  = 8'h2F;
  localparam logic [7:0] XS_CFG_RESET = 8'h0C;

  // Number of visible internal bytes for a size select value.
  function automatic int unsigned xs_visible(input logic [1:0] sel, input int unsigned blk);
    return (int'(sel) + 1) * blk;
  endfunction

  function automatic xs_cfg_t xs_decode(input logic [7:0] raw);
    xs_cfg_t c;
    c.stretch  = raw[5];
    c.size_sel = raw[3:2];
    c.map_ext  = raw[1];
    c.ale_off  = raw[0];
    return c;
  endfunction

endpackage

// File: rtl/xdata_steer_cfg.sv
module xdata_steer_cfg
  import xdata_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output xs_cfg_t    cfg
);

  logic [7:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= XS_CFG_RESET;
    else if (we) raw_q <= wdata & XS_CFG_MASK;
  end

  assign rdata = raw_q;
  assign cfg   = xs_decode(raw_q);

endmodule

// File: rtl/xdata_steer_route.sv
module xdata_steer_route
  import xdata_steer_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 256
)(
  input  xs_cfg_t     cfg,
  input  logic        wide,
  input  logic [15:0] addr,
  output logic        to_int
);

  logic [31:0] eff_addr;
  logic [31:0] limit;

  always_comb begin
    eff_addr = wide ? {16'h0, addr} : {24'h0, addr[7:0]};
    limit    = xs_visible(cfg.size_sel, BLOCK_BYTES);
    to_int   = !cfg.map_ext && (eff_addr < limit);
  end

endmodule

// File: rtl/xdata_steer_seq.sv
module xdata_steer_seq
  import xdata_steer_pkg::*;
#(
  parameter int unsigned IRAM_AW   = 10,
  parameter int unsigned SHORT_LEN = 6,
  parameter int unsigned LONG_LEN  = 30
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               acc_int,
  input  logic               acc_we,
  input  logic               acc_wide,
  input  logic [15:0]        acc_addr,
  input  logic [7:0]         acc_wdata,
  input  xs_cfg_t            cfg,
  output logic               busy,
  output logic               rd_valid,
  output logic [7:0]         rd_data,
  output logic               iram_en,
  output logic               iram_we,
  output logic [IRAM_AW-1:0] iram_addr,
  output logic [7:0]         iram_wdata,
  input  logic [7:0]         iram_rdata,
  output logic [7:0]         bus_lo_out,
  output logic               bus_lo_oe,
  input  logic [7:0]         bus_lo_in,
  output logic [7:0]         bus_hi,
  output logic               bus_ale,
  output logic               bus_rd_n,
  output logic               bus_wr_n
);

  localparam int unsigned MAXLEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int unsigned CW     = $clog2(MAXLEN) + 1;

  function automatic logic [CW-1:0] last_count(input logic stretch);
    return stretch ? CW'(LONG_LEN - 1) : CW'(SHORT_LEN - 1);
  endfunction

  xs_state_e     state;
  logic [15:0]   a_q;
  logic          wide_q, we_q, ale_off_q;
  logic [7:0]    wd_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      a_q       <= '0;
      wide_q    <= 1'b0;
      we_q      <= 1'b0;
      ale_off_q <= 1'b0;
      wd_q      <= '0;
      cnt       <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          a_q       <= acc_wide ? acc_addr : {8'h00, acc_addr[7:0]};
          wide_q    <= acc_wide;
          we_q      <= acc_we;
          wd_q      <= acc_wdata;
          ale_off_q <= cfg.ale_off;
          cnt       <= last_count(cfg.stretch);
          state     <= acc_int ? ST_INT : ST_ADR;
        end
        ST_INT: state <= we_q ? ST_IDLE : ST_IRD;
        ST_IRD: begin
          rd_data  <= iram_rdata;
          rd_valid <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_ADR: state <= ST_STB;
        ST_STB: begin
          if (cnt == '0) begin
            if (!we_q) begin
              rd_data  <= bus_lo_in;
              rd_valid <= 1'b1;
            end
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic ext_on;
  assign ext_on = (state == ST_ADR) || (state == ST_STB);

  assign busy       = (state != ST_IDLE);
  assign iram_en    = (state == ST_INT);
  assign iram_we    = (state == ST_INT) && we_q;
  assign iram_addr  = a_q[IRAM_AW-1:0];
  assign iram_wdata = wd_q;

  assign bus_hi     = (ext_on && wide_q) ? a_q[15:8] : 8'hFF;
  assign bus_ale    = (state == ST_ADR) && !ale_off_q;
  assign bus_lo_oe  = (state == ST_ADR) || ((state == ST_STB) && we_q);
  assign bus_lo_out = (state == ST_ADR) ? a_q[7:0] :
                      ((state == ST_STB) && we_q) ? wd_q : 8'hFF;
  assign bus_rd_n   = !((state == ST_STB) && !we_q);
  assign bus_wr_n   = !((state == ST_STB) && we_q);

endmodule

// File: rtl/xdata_steer.sv
module xdata_steer
  import xdata_steer_pkg::*;
#(
  parameter int unsigned IRAM_AW     = 10,
  parameter int unsigned BLOCK_BYTES = 256,
  parameter int unsigned SHORT_LEN   = 6,
  parameter int unsigned LONG_LEN    = 30
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic               req_wide,
  input  logic [15:0]        req_addr,
  input  logic [7:0]         req_wdata,
  output logic               busy,
  output logic               rd_valid,
  output logic [7:0]         rd_data,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_q,
  output logic               iram_en,
  output logic               iram_we,
  output logic [IRAM_AW-1:0] iram_addr,
  output logic [7:0]         iram_wdata,
  input  logic [7:0]         iram_rdata,
  output logic [7:0]         bus_lo_out,
  output logic               bus_lo_oe,
  input  logic [7:0]         bus_lo_in,
  output logic [7:0]         bus_hi,
  output logic               bus_ale,
  output logic               bus_rd_n,
  output logic               bus_wr_n
);

  xs_cfg_t cfg;
  logic    acc_accept;
  logic    route_int;
  logic    strobe_on;

  assign acc_accept = req_valid && !busy;
  assign strobe_on  = !bus_rd_n || !bus_wr_n;

  xdata_steer_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_q),
    .cfg   (cfg)
  );

  xdata_steer_route #(.BLOCK_BYTES(BLOCK_BYTES)) u_route (
    .cfg    (cfg),
    .wide   (req_wide),
    .addr   (req_addr),
    .to_int (route_int)
  );

  xdata_steer_seq #(
    .IRAM_AW   (IRAM_AW),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (acc_accept),
    .acc_int    (route_int),
    .acc_we     (req_we),
    .acc_wide   (req_wide),
    .acc_addr   (req_addr),
    .acc_wdata  (req_wdata),
    .cfg        (cfg),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .iram_en    (iram_en),
    .iram_we    (iram_we),
    .iram_addr  (iram_addr),
    .iram_wdata (iram_wdata),
    .iram_rdata (iram_rdata),
    .bus_lo_out (bus_lo_out),
    .bus_lo_oe  (bus_lo_oe),
    .bus_lo_in  (bus_lo_in),
    .bus_hi     (bus_hi),
    .bus_ale    (bus_ale),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n)
  );

endmodule

// File: rtl/xdata_steer_chk.sv
module xdata_steer_chk #(
  parameter int unsigned SHORT_LEN = 6,
  parameter int unsigned LONG_LEN  = 30
)(
  input logic       clk,
  input logic       rst_n,
  input logic       acc_accept,
  input logic       busy,
  input logic [7:0] cfg_q,
  input logic       iram_en,
  input logic       bus_ale,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       bus_lo_oe,
  input logic [7:0] bus_lo_out,
  input logic [7:0] bus_hi,
  input logic       strobe_on
);

  logic [7:0] run_len;
  logic [7:0] exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      exp_len <= 8'(SHORT_LEN);
    end else begin
      run_len <= strobe_on ? run_len + 1'b1 : 8'h0;
      if (acc_accept) exp_len <= cfg_q[5] ? 8'(LONG_LEN) : 8'(SHORT_LEN);
    end
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[7:6] == 2'b00) && !cfg_q[4]);

  p_int_ports_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iram_en |-> (bus_rd_n && bus_wr_n && !bus_ale && !bus_lo_oe && bus_hi == 8'hFF));

  p_ale_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (!bus_ale && strobe_on));

  p_hi_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on)) |-> $stable(bus_hi));

  p_strobe_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_on) |-> (run_len == exp_len));

  p_wdata_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_lo_out) && bus_lo_oe));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_accept |=> busy);

endmodule

bind xdata_steer xdata_steer_chk #(
  .SHORT_LEN (SHORT_LEN),
  .LONG_LEN  (LONG_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_accept (acc_accept),
  .busy       (busy),
  .cfg_q      (cfg_q),
  .iram_en    (iram_en),
  .bus_ale    (bus_ale),
  .bus_rd_n   (bus_rd_n),
  .bus_wr_n   (bus_wr_n),
  .bus_lo_oe  (bus_lo_oe),
  .bus_lo_out (bus_lo_out),
  .bus_hi     (bus_hi),
  .strobe_on  (strobe_on)
);

// File: tb/xdata_steer_bench.sv
module xdata_steer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, rd_valid;
  logic [7:0]  rd_data;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_q;
  logic        iram_en, iram_we;
  logic [9:0]  iram_addr;
  logic [7:0]  iram_wdata;
  logic [7:0]  iram_rdata = '0;
  logic [7:0]  bus_lo_out, bus_lo_in, bus_hi;
  logic        bus_lo_oe, bus_ale, bus_rd_n, bus_wr_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xdata_steer u_xdata_steer (.*);

  // Internal RAM model with one-clock read latency.
  logic [7:0] mem [1024];
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  always @(posedge clk) if (iram_en) begin
    if (iram_we) mem[iram_addr] <= iram_wdata;
    iram_rdata <= mem[iram_addr];
  end

  // External device model: read data derived from the address seen.
  logic [7:0] last_lo = 8'h00;
  always @(posedge clk) if (bus_lo_oe && bus_rd_n && bus_wr_n) last_lo <= bus_lo_out;
  assign bus_lo_in = bus_hi ^ last_lo ^ 8'h5A;

  typedef struct packed {
    logic [7:0]  cfg;
    logic        we;
    logic        wide;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        ext;
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'h0C, 1'b1, 1'b1, 16'h0100, 8'hA1, 1'b0, 8'h00},
    '{8'h0C, 1'b0, 1'b1, 16'h0100, 8'h00, 1'b0, 8'hA1},
    '{8'h0C, 1'b1, 1'b1, 16'h03FF, 8'hB2, 1'b0, 8'h00},
    '{8'h0C, 1'b0, 1'b1, 16'h03FF, 8'h00, 1'b0, 8'hB2},
    '{8'h0C, 1'b1, 1'b1, 16'h0400, 8'hC3, 1'b1, 8'h00},
    '{8'h00, 1'b1, 1'b1, 16'h0100, 8'hD4, 1'b1, 8'h00},
    '{8'h04, 1'b0, 1'b1, 16'h0100, 8'h00, 1'b0, 8'hA1},
    '{8'h04, 1'b1, 1'b1, 16'h0200, 8'hE5, 1'b1, 8'h00},
    '{8'h08, 1'b0, 1'b1, 16'h0200, 8'h00, 1'b0, 8'h00},
    '{8'h08, 1'b0, 1'b1, 16'h02FF, 8'h00, 1'b0, 8'h00},
    '{8'h08, 1'b1, 1'b1, 16'h0300, 8'h66, 1'b1, 8'h00},
    '{8'h0C, 1'b1, 1'b0, 16'hFFA0, 8'h77, 1'b0, 8'h00},
    '{8'h0C, 1'b0, 1'b0, 16'h12A0, 8'h00, 1'b0, 8'h77},
    '{8'h0E, 1'b0, 1'b0, 16'h3342, 8'h00, 1'b1, 8'hE7},
    '{8'h2C, 1'b1, 1'b1, 16'h1234, 8'h5A, 1'b1, 8'h00},
    '{8'h2C, 1'b0, 1'b1, 16'hBEEF, 8'h00, 1'b1, 8'h0B},
    '{8'h0D, 1'b0, 1'b1, 16'h8000, 8'h00, 1'b1, 8'hDA}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Observations of one access.
  int n_busy, n_ale, n_stb;
  bit seen_int, touched, hi_bad, wd_bad, ale_bad, got_rv;
  logic [7:0] got_rd;

  task automatic access(input logic we, input logic wide, input logic [15:0] a,
                        input logic [7:0] wd, input logic [7:0] exp_hi);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_wide = wide; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n_busy = 0; n_ale = 0; n_stb = 0;
    seen_int = 0; touched = 0; hi_bad = 0; wd_bad = 0; ale_bad = 0;
    while (busy && n_busy < 100) begin
      if (bus_ale) begin
        n_ale++;
        if (bus_lo_out != a[7:0] || !bus_lo_oe) ale_bad = 1;
      end
      if (!bus_rd_n || !bus_wr_n) n_stb++;
      if (!bus_wr_n && (bus_lo_out != wd || !bus_lo_oe)) wd_bad = 1;
      if (iram_en) seen_int = 1;
      if (!bus_rd_n || !bus_wr_n || bus_ale || bus_lo_oe || bus_hi != 8'hFF) touched = 1;
      if ((bus_lo_oe || !bus_rd_n || !bus_wr_n) && bus_hi != exp_hi) hi_bad = 1;
      @(negedge clk);
      n_busy++;
    end
    got_rv = rd_valid;
    got_rd = rd_data;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cfg_q == 8'h0C, "R1 cfg reset", cfg_q, 8'h0C);
    check(!busy && bus_rd_n && bus_wr_n && !bus_ale && !bus_lo_oe && bus_hi == 8'hFF,
          "R1 idle pins", {busy, bus_rd_n, bus_wr_n, bus_ale, bus_lo_oe}, 5'b01100);

    // R2: reserved bits read 0
    set_cfg(8'hFF);
    check(cfg_q == 8'h2F, "R2 reserved mask", cfg_q, 8'h2F);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      int len;
      logic [7:0] ehi;
      v = VECS[k];
      len = v.cfg[5] ? 30 : 6;
      ehi = v.wide ? v.addr[15:8] : 8'hFF;
      set_cfg(v.cfg);
      access(v.we, v.wide, v.addr, v.wd, ehi);
      // R3 R5 R6: routing decision
      check((n_stb > 0) == v.ext && seen_int == !v.ext, $sformatf("R3 R5 R6 route vec%0d", k),
            n_stb > 0, v.ext);
      if (v.ext) begin
        check(n_stb == len, $sformatf("R8 strobe length vec%0d", k), n_stb, len);
        check(n_busy == len + 1, $sformatf("R8 busy length vec%0d", k), n_busy, len + 1);
        check(n_ale == (v.cfg[0] ? 0 : 1) && !ale_bad, $sformatf("R7 R12 latch vec%0d", k),
              n_ale, v.cfg[0] ? 0 : 1);
        check(!hi_bad, $sformatf("R7 R6 high port vec%0d", k), hi_bad, 0);
        if (v.we) check(!wd_bad, $sformatf("R9 write data vec%0d", k), wd_bad, 0);
      end else begin
        check(!touched, $sformatf("R4 pins idle vec%0d", k), touched, 0);
        check(n_busy == (v.we ? 1 : 2), $sformatf("R4 busy length vec%0d", k),
              n_busy, v.we ? 1 : 2);
      end
      if (!v.we) begin
        check(got_rv && got_rd == v.rd, $sformatf("R10 R4 read data vec%0d", k), got_rd, v.rd);
      end else begin
        check(!got_rv, $sformatf("R10 no valid on write vec%0d", k), got_rv, 0);
      end
    end

    // R11: request while busy is ignored
    set_cfg(8'h0C);
    fork
      access(1'b1, 1'b1, 16'h0500, 8'h11, 8'h05);
      begin
        @(negedge clk); @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_wide = 1'b1; req_addr = 16'h0010; req_wdata = 8'h99;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    check(n_busy == 7, "R11 busy span", n_busy, 7);
    @(negedge clk);
    check(!busy, "R11 no second access", busy, 0);
    access(1'b0, 1'b1, 16'h0010, 8'h00, 8'hFF);
    check(got_rv && got_rd == 8'h00, "R11 ignored write left RAM", got_rd, 8'h00);

    // R12 with long strobe: latch disabled, timing unchanged
    set_cfg(8'h2D);
    access(1'b1, 1'b1, 16'h4411, 8'h3C, 8'h44);
    check(n_ale == 0 && n_stb == 30 && n_busy == 31, "R12 no latch long strobe", n_stb, 30);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule